// File: doc/BRIEF.md
# Decade-Cascade Strobe Divider

This block divides a reference clock by one thousand. It emits a strobe that is high for exactly one reference period once every thousand enabled cycles. From a 10 MHz reference it produces a 10 kHz pulse train with a 100 ns high time, which is a 0.1% duty cycle and not a square wave.

The count is kept as a chain of synchronous decimal digits. Every digit runs on the same clock. The carry from one digit to the next is a plain combinational decode. The pulse request is the single overall state in which every digit reads zero. That request is captured by a D flip-flop on the reference clock, so any glitch in the decode never reaches the pin. The reference clock itself is never gated into the output.

A synchronous active-high reset clears the count. A count enable freezes the count when low, and the strobe stays low while the enable is low.

Top module: `strobe_div1000`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `count_bcd` becomes 0 and `strobe` becomes 0 after that edge.
- R2: `strobe` is never high for two consecutive cycles.
- R3: The count value runs 0 to 999 in enabled cycles. An enabled edge taken at 999 returns it to 0.
- R4: `count_bcd` holds three BCD digits, 4 bits each. Digit 0 (units) is in bits [3:0], tens in [7:4] and hundreds in [11:8]. No digit ever exceeds 9.
- R5: An edge with `en` low leaves `count_bcd` unchanged and drives `strobe` low.
- R6: `strobe` is high in the cycle after an enabled edge taken while the count was 0. With `en` held high, successive rising edges of `strobe` are exactly 1000 clocks apart.
- R7: A digit advances on an enabled edge only when every lower digit reads 9, and it wraps from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| strobe | output | 1 | Registered one-period pulse |
| count_bcd | output | 12 | Current count as three BCD digits |

## Verification
The assertions assume that `rst` and `en` change only away from the rising edge and are stable at each edge. The hold property also assumes reset is not released between the edge it checks and the next sample. The bench drives both inputs on the falling edge and holds each reset for several cycles, so these assumptions are met. The enable is random with a strong bias toward high, which makes both frozen stretches and full wraps through 999 occur. Directed phases hold the enable low at count 0, and assert reset mid-count.

// File: rtl/strobe_div1000.sv
module strobe_div1000 #(
  parameter int DIGITS  = 3,
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10,
  localparam int CW     = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          strobe,
  output logic [CW-1:0] count_bcd
);

  logic [DIGITS-1:0] carry;
  logic [DIGITS-1:0] at_top;
  logic [DIGITS-1:0] at_zero;

  assign carry[0] = en;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [DIGIT_W-1:0] d;

    assign at_top[i]  = (d == DIGIT_W'(RADIX - 1));
    assign at_zero[i] = (d == '0);

    if (i < DIGITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] & at_top[i];
    end

    always_ff @(posedge clk) begin
      if (rst)
        d <= '0;
      else if (carry[i])
        d <= at_top[i] ? '0 : d + DIGIT_W'(1);
    end

    assign count_bcd[i*DIGIT_W +: DIGIT_W] = d;
  end

  always_ff @(posedge clk) begin
    if (rst)
      strobe <= 1'b0;
    else
      strobe <= en & (&at_zero);
  end

endmodule

// File: rtl/strobe_div1000_chk.sv
module strobe_div1000_chk #(
  parameter int DIGITS  = 3,
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10,
  localparam int CW     = DIGITS * DIGIT_W
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          strobe,
  input logic [CW-1:0] count_bcd
);

  logic [DIGITS-1:0] top_v;
  logic [DIGITS-1:0] ok_v;
  logic              rst_q;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    assign top_v[i] = (count_bcd[i*DIGIT_W +: DIGIT_W] == DIGIT_W'(RADIX - 1));
    assign ok_v[i]  = (count_bcd[i*DIGIT_W +: DIGIT_W] <  DIGIT_W'(RADIX));
  end

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) AST_RESET_CLEARS: assert (count_bcd == '0 && !strobe); // R1
  end

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && (&top_v)) |=> (count_bcd == '0)); // R3

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (&ok_v)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count_bcd) && !strobe)); // R5

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ($past(en) && $past(count_bcd) == '0)); // R6

endmodule

bind strobe_div1000 strobe_div1000_chk #(
  .DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .RADIX(RADIX)
) chk (
  .clk(clk), .rst(rst), .en(en), .strobe(strobe), .count_bcd(count_bcd)
);

// File: tb/strobe_div1000_test.sv
module strobe_div1000_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic strobe;
  logic [11:0] count_bcd;

  int errors = 0;
  int checks = 0;
  int m_cnt = 0;
  bit m_stb = 1'b0;
  bit prev_stb = 1'b0;
  longint cyc = 0;
  longint last_rise = -1;
  bit period_mode = 1'b0;
  bit done = 1'b0;

  strobe_div1000 uut (.clk(clk), .rst(rst), .en(en), .strobe(strobe), .count_bcd(count_bcd));

  always #5 clk = ~clk;

  function automatic int bcd_val(logic [11:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [11:0] to_bcd(int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit e, string req);
    rst = r;
    en  = e;
    @(posedge clk);
    cyc++;
    if (r) begin
      m_cnt = 0;
      m_stb = 1'b0;
    end else begin
      m_stb = e && (m_cnt == 0);
      if (e) m_cnt = (m_cnt + 1) % 1000;
    end
    @(negedge clk);
    check(count_bcd == to_bcd(m_cnt), req, "count", bcd_val(count_bcd), m_cnt);
    check(strobe == m_stb, req, "strobe", int'(strobe), int'(m_stb));
    check(count_bcd[3:0] <= 9 && count_bcd[7:4] <= 9 && count_bcd[11:8] <= 9,
          "R4", "digit range", int'(count_bcd), m_cnt);
    if (prev_stb)
      check(!strobe, "R2", "pulse width", int'(strobe), 0);
    if (strobe && !prev_stb) begin
      if (period_mode && last_rise >= 0)
        check(cyc - last_rise == 1000, "R6", "rise spacing", int'(cyc - last_rise), 1000);
      last_rise = cyc;
    end
    prev_stb = strobe;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
    // R6 / R3 / R7: free run across several full periods
    period_mode = 1'b1;
    for (int i = 0; i < 3200; i++) step(1'b0, 1'b1, "R6");
    period_mode = 1'b0;
    // R5: hold with enable low, including at count 0
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R5");
    while (m_cnt != 0) step(1'b0, 1'b1, "R3");
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R6");
    check(strobe == 1'b1, "R6", "strobe after enabled zero", int'(strobe), 1);
    // R7: carry into tens and hundreds digits
    while (m_cnt != 99) step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    check(count_bcd == 12'h100, "R7", "hundreds carry", bcd_val(count_bcd), 100);
    // R1: mid-count reset
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, "R1");
    check(count_bcd == 12'h000 && !strobe, "R1", "reset state", bcd_val(count_bcd), 0);
    // random enable pattern
    for (int i = 0; i < 6000; i++) begin
      bit e = ($urandom % 8) != 0;
      bit r = ($urandom % 2000) == 0;
      step(r, e, r ? "R1" : (e ? "R3" : "R5"));
    end
    finish_run();
  end
endmodule